// File: doc/BRIEF.md
# Super I/O configuration port controller

This block is the configuration front end of a multi-function I/O controller. It sits on a byte-wide host I/O bus and decodes two adjacent addresses. The lower address is the index port and the upper one is the data port. A strap input places the pair at 0x3F0/0x3F1 or at 0x370/0x371. After reset the block is in run mode, where the configuration registers cannot be reached. The host unlocks it by writing 0x55 to the index port twice with nothing in between. It then writes a register index to the index port and reads or writes that register through the data port. Writing 0xAA to the index port locks the block again.

Some registers are global: the logical device selector, the identity bytes, a power-control view, power management and an oscillator byte. Indices 0x30 and above reach a register bank that belongs to the logical device currently selected at index 0x07. Each bank drives the signals that a downstream decoder needs: an enable bit, a 16-bit base address, a primary IRQ and, where the device has them, a secondary IRQ, a DMA channel and floppy mode and option bytes.

Top module: `sio_cfg_port`

## Requirements
- R1: Two consecutive writes of 0x55 to the index port put the block in configuration mode, and `cfg_mode` is high from the clock edge of the second write.
- R2: Any write to the index or data port other than 0x55 that falls between the two unlock writes restarts the unlock sequence, so one further 0x55 does not unlock.
- R3: In configuration mode, writing 0xAA to the index port returns the block to run mode. In run mode, data-port writes change no register, and reads of either port return 0xFF.
- R4: With `strap_alt`=0 the ports are 0x3F0 (index) and 0x3F1 (data). With `strap_alt`=1 they are 0x370 and 0x371. Reads at any other address, or with `io_rd` low, return 0x00.
- R5: In configuration mode, reading the index port returns the last index written. Index 0x20 reads the device ID 0x02 and index 0x21 reads the revision (default 0x01).
- R6: Index 0x07 holds the logical device number. For the selected device, 0x30 bit 0 is its enable (other bits read 0), 0x60/0x61 are the high and low bytes of its base address, and 0x70 is its primary IRQ. These drive `dev_enable[n]`, `dev_base[16n+:16]` and `dev_irq[8n+:8]`.
- R7: Index 0x72 (secondary IRQ, `dev_irq2`) exists only for device 7. Index 0x74 (DMA, `dev_dma`) exists only for devices 0 and 3. For other devices these indices read 0x00 and writes to them have no effect.
- R8: Device 0 has read/write registers at 0x90 (mode) and 0x91 (option), driving `fdd_mode` and `fdd_option`. A read-modify-write that sets bits 3:1 keeps the other bits.
- R9: Index 0x22 is read-only. Its bit n equals `dev_enable[n]` for n = 0..5, and bits 7:6 read 0.
- R10: Indices 0x23 and 0x24 are global read/write bytes.
- R11: Unimplemented indices read 0x00 and ignore writes. When the device number is 9 or more, every bank index reads 0x00 and writes change no output.
- R12: Reset gives run mode, index 0, device number 0, all devices disabled, and all base, IRQ, DMA and floppy fields zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| strap_alt | input | 1 | Selects the alternate port pair 0x370/0x371 |
| io_addr | input | 16 | Host I/O address |
| io_wr | input | 1 | Host write strobe, one cycle per write |
| io_rd | input | 1 | Host read strobe |
| io_wdata | input | 8 | Host write data |
| io_rdata | output | 8 | Combinational read data |
| cfg_mode | output | 1 | High in configuration mode |
| dev_enable | output | 9 | Enable bit per logical device |
| dev_base | output | 144 | 16-bit base address per device |
| dev_irq | output | 72 | Primary IRQ per device |
| dev_irq2 | output | 72 | Secondary IRQ per device (device 7 only) |
| dev_dma | output | 72 | DMA channel per device (devices 0 and 3 only) |
| fdd_mode | output | 8 | Floppy mode byte |
| fdd_option | output | 8 | Floppy option byte |

## Verification
A vector table drives a full unlock, programs one serial device, and reads back both its own bank and a neighbouring bank. This shows that the bank select decides which storage a data-port access reaches. Directed sequences then interrupt the unlock with a data-port write and with a non-key index write. They also write to the data port while locked, write to device-only indices on devices that lack them, and select a device number past the last device. Each of these is judged by readback or by the output buses. A final reset with the alternate strap shows that unlocking follows the strapped port pair and that reset clears the selector.

// File: rtl/sio_cfg_pkg.sv
package sio_cfg_pkg;
   localparam logic [7:0] IDX_LDN     = 8'h07;
   localparam logic [7:0] IDX_DEVID   = 8'h20;
   localparam logic [7:0] IDX_DEVREV  = 8'h21;
   localparam logic [7:0] IDX_PWRCTL  = 8'h22;
   localparam logic [7:0] IDX_PWRMGT  = 8'h23;
   localparam logic [7:0] IDX_OSC     = 8'h24;
   localparam logic [7:0] IDX_ACT     = 8'h30;
   localparam logic [7:0] IDX_BASE_HI = 8'h60;
   localparam logic [7:0] IDX_BASE_LO = 8'h61;
   localparam logic [7:0] IDX_IRQ     = 8'h70;
   localparam logic [7:0] IDX_IRQ2    = 8'h72;
   localparam logic [7:0] IDX_DMA     = 8'h74;
   localparam logic [7:0] IDX_FMODE   = 8'h90;
   localparam logic [7:0] IDX_FOPT    = 8'h91;

   localparam logic [7:0] KEY_UNLOCK  = 8'h55;
   localparam logic [7:0] KEY_LOCK    = 8'hAA;

   localparam int LD_FLOPPY    = 0;
   localparam int LD_PARALLEL  = 3;
   localparam int LD_KEYBOARD  = 7;
   localparam int PWR_CTL_DEVS = 6;

   typedef enum logic [1:0] {
      M_RUN   = 2'd0,
      M_ARMED = 2'd1,
      M_CFG   = 2'd2
   } cfg_state_e;
endpackage

// File: rtl/sio_key_fsm.sv
module sio_key_fsm
   import sio_cfg_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       idx_wr,
   input  logic       dat_wr,
   input  logic [7:0] wdata,
   output logic       cfg_mode
);
   cfg_state_e state_q, state_d;

   always_comb begin
      state_d = state_q;
      unique case (state_q)
         M_RUN: begin
            if (idx_wr && wdata == KEY_UNLOCK) state_d = M_ARMED;
         end
         M_ARMED: begin
            if (idx_wr && wdata == KEY_UNLOCK) state_d = M_CFG;
            else if (idx_wr || dat_wr)         state_d = M_RUN;
         end
         M_CFG: begin
            if (idx_wr && wdata == KEY_LOCK) state_d = M_RUN;
         end
         default: state_d = M_RUN;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) state_q <= M_RUN;
      else        state_q <= state_d;
   end

   assign cfg_mode = (state_q == M_CFG);

   assert_unlock_second_key_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == M_ARMED && idx_wr && wdata == KEY_UNLOCK) |=> cfg_mode);
   assert_unlock_needs_arm_R1: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(cfg_mode) |-> $past(state_q == M_ARMED));
   assert_restart_on_data_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == M_ARMED && dat_wr && !idx_wr) |=> (state_q == M_RUN));
   assert_lock_key_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_mode && idx_wr && wdata == KEY_LOCK) |=> !cfg_mode);
endmodule

// File: rtl/sio_ld_bank.sv
module sio_ld_bank
   import sio_cfg_pkg::*;
#(
   parameter bit HAS_IRQ2 = 1'b0,
   parameter bit HAS_DMA  = 1'b0,
   parameter bit HAS_FDD  = 1'b0
)(
   input  logic        clk,
   input  logic        rst_n,
   input  logic        sel,
   input  logic        wr,
   input  logic [7:0]  idx,
   input  logic [7:0]  wdata,
   output logic [7:0]  rdata,
   output logic        act,
   output logic [15:0] base,
   output logic [7:0]  irq,
   output logic [7:0]  irq2,
   output logic [7:0]  dma,
   output logic [7:0]  fmode,
   output logic [7:0]  fopt
);
   logic       we;
   logic       act_q;
   logic [7:0] base_hi_q, base_lo_q, irq_q;

   assign we = sel && wr;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         act_q     <= 1'b0;
         base_hi_q <= '0;
         base_lo_q <= '0;
         irq_q     <= '0;
      end else if (we) begin
         if (idx == IDX_ACT)     act_q     <= wdata[0];
         if (idx == IDX_BASE_HI) base_hi_q <= wdata;
         if (idx == IDX_BASE_LO) base_lo_q <= wdata;
         if (idx == IDX_IRQ)     irq_q     <= wdata;
      end
   end

   generate
      if (HAS_IRQ2) begin : g_irq2
         logic [7:0] irq2_q;
         always_ff @(posedge clk) begin
            if (!rst_n)                     irq2_q <= '0;
            else if (we && idx == IDX_IRQ2) irq2_q <= wdata;
         end
         assign irq2 = irq2_q;
      end else begin : g_no_irq2
         assign irq2 = '0;
      end

      if (HAS_DMA) begin : g_dma
         logic [7:0] dma_q;
         always_ff @(posedge clk) begin
            if (!rst_n)                    dma_q <= '0;
            else if (we && idx == IDX_DMA) dma_q <= wdata;
         end
         assign dma = dma_q;
      end else begin : g_no_dma
         assign dma = '0;
      end

      if (HAS_FDD) begin : g_fdd
         logic [7:0] fmode_q, fopt_q;
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               fmode_q <= '0;
               fopt_q  <= '0;
            end else if (we) begin
               if (idx == IDX_FMODE) fmode_q <= wdata;
               if (idx == IDX_FOPT)  fopt_q  <= wdata;
            end
         end
         assign fmode = fmode_q;
         assign fopt  = fopt_q;
      end else begin : g_no_fdd
         assign fmode = '0;
         assign fopt  = '0;
      end
   endgenerate

   assign act  = act_q;
   assign base = {base_hi_q, base_lo_q};
   assign irq  = irq_q;

   always_comb begin
      unique case (idx)
         IDX_ACT:     rdata = {7'd0, act_q};
         IDX_BASE_HI: rdata = base_hi_q;
         IDX_BASE_LO: rdata = base_lo_q;
         IDX_IRQ:     rdata = irq_q;
         IDX_IRQ2:    rdata = irq2;
         IDX_DMA:     rdata = dma;
         IDX_FMODE:   rdata = fmode;
         IDX_FOPT:    rdata = fopt;
         default:     rdata = 8'h00;
      endcase
   end

   assert_act_holds_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !(we && idx == IDX_ACT) |=> $stable(act));
   assert_base_holds_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !we |=> $stable(base));
endmodule

// File: rtl/sio_cfg_port.sv
module sio_cfg_port
   import sio_cfg_pkg::*;
#(
   parameter int          NUM_DEV  = 9,
   parameter int          IO_AW    = 16,
   parameter int unsigned PRI_BASE = 32'h3F0,
   parameter int unsigned ALT_BASE = 32'h370,
   parameter logic [7:0]  DEV_ID   = 8'h02,
   parameter logic [7:0]  DEV_REV  = 8'h01
)(
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 strap_alt,
   input  logic [IO_AW-1:0]     io_addr,
   input  logic                 io_wr,
   input  logic                 io_rd,
   input  logic [7:0]           io_wdata,
   output logic [7:0]           io_rdata,
   output logic                 cfg_mode,
   output logic [NUM_DEV-1:0]   dev_enable,
   output logic [NUM_DEV*16-1:0] dev_base,
   output logic [NUM_DEV*8-1:0] dev_irq,
   output logic [NUM_DEV*8-1:0] dev_irq2,
   output logic [NUM_DEV*8-1:0] dev_dma,
   output logic [7:0]           fdd_mode,
   output logic [7:0]           fdd_option
);
   localparam logic [IO_AW-1:0] PRI_IDX = PRI_BASE[IO_AW-1:0];
   localparam logic [IO_AW-1:0] ALT_IDX = ALT_BASE[IO_AW-1:0];
   localparam logic [IO_AW-1:0] ONE     = {{(IO_AW-1){1'b0}}, 1'b1};

   generate
      if (NUM_DEV < LD_KEYBOARD + 1 || NUM_DEV > 255) begin : g_bad_ndev
         $error("sio_cfg_port: NUM_DEV must cover the keyboard device and fit a byte");
      end
      if (IO_AW < 10 || IO_AW > 32) begin : g_bad_aw
         $error("sio_cfg_port: IO_AW out of range");
      end
      if ((PRI_BASE % 2) != 0 || (ALT_BASE % 2) != 0) begin : g_bad_base
         $error("sio_cfg_port: port pair bases must be even");
      end
   endgenerate

   logic [IO_AW-1:0] idx_addr, dat_addr;
   logic             hit_idx, hit_dat, idx_wr, dat_wr;
   logic [7:0]       index_q, ldn_q, pwrmgt_q, osc_q;
   logic [7:0]       pwr_ctl;
   logic [7:0]       bank_val;

   assign idx_addr = strap_alt ? ALT_IDX : PRI_IDX;
   assign dat_addr = idx_addr + ONE;
   assign hit_idx  = (io_addr == idx_addr);
   assign hit_dat  = (io_addr == dat_addr);
   assign idx_wr   = io_wr && hit_idx;
   assign dat_wr   = io_wr && hit_dat;

   sio_key_fsm u_key (
      .clk      (clk),
      .rst_n    (rst_n),
      .idx_wr   (idx_wr),
      .dat_wr   (dat_wr),
      .wdata    (io_wdata),
      .cfg_mode (cfg_mode)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         index_q  <= '0;
         ldn_q    <= '0;
         pwrmgt_q <= '0;
         osc_q    <= '0;
      end else if (cfg_mode) begin
         if (idx_wr && io_wdata != KEY_LOCK) index_q <= io_wdata;
         if (dat_wr) begin
            if (index_q == IDX_LDN)    ldn_q    <= io_wdata;
            if (index_q == IDX_PWRMGT) pwrmgt_q <= io_wdata;
            if (index_q == IDX_OSC)    osc_q    <= io_wdata;
         end
      end
   end

   logic [7:0]  bank_rd    [NUM_DEV];
   logic [15:0] bank_base  [NUM_DEV];
   logic [7:0]  bank_irq   [NUM_DEV];
   logic [7:0]  bank_irq2  [NUM_DEV];
   logic [7:0]  bank_dma   [NUM_DEV];
   logic [7:0]  bank_fmode [NUM_DEV];
   logic [7:0]  bank_fopt  [NUM_DEV];

   generate
      for (genvar d = 0; d < NUM_DEV; d++) begin : g_bank
         sio_ld_bank #(
            .HAS_IRQ2 (d == LD_KEYBOARD),
            .HAS_DMA  (d == LD_FLOPPY || d == LD_PARALLEL),
            .HAS_FDD  (d == LD_FLOPPY)
         ) u_bank (
            .clk   (clk),
            .rst_n (rst_n),
            .sel   (cfg_mode && (ldn_q == 8'(d))),
            .wr    (dat_wr),
            .idx   (index_q),
            .wdata (io_wdata),
            .rdata (bank_rd[d]),
            .act   (dev_enable[d]),
            .base  (bank_base[d]),
            .irq   (bank_irq[d]),
            .irq2  (bank_irq2[d]),
            .dma   (bank_dma[d]),
            .fmode (bank_fmode[d]),
            .fopt  (bank_fopt[d])
         );
         assign dev_base[d*16 +: 16] = bank_base[d];
         assign dev_irq[d*8 +: 8]    = bank_irq[d];
         assign dev_irq2[d*8 +: 8]   = bank_irq2[d];
         assign dev_dma[d*8 +: 8]    = bank_dma[d];
      end
   endgenerate

   assign fdd_mode   = bank_fmode[LD_FLOPPY];
   assign fdd_option = bank_fopt[LD_FLOPPY];
   assign pwr_ctl    = {{(8-PWR_CTL_DEVS){1'b0}}, dev_enable[PWR_CTL_DEVS-1:0]};

   always_comb begin
      bank_val = 8'h00;
      for (int d = 0; d < NUM_DEV; d++) begin
         if (ldn_q == 8'(d)) bank_val = bank_rd[d];
      end
   end

   always_comb begin
      if (!io_rd || !(hit_idx || hit_dat)) begin
         io_rdata = 8'h00;
      end else if (!cfg_mode) begin
         io_rdata = 8'hFF;
      end else if (hit_idx) begin
         io_rdata = index_q;
      end else begin
         unique case (index_q)
            IDX_LDN:    io_rdata = ldn_q;
            IDX_DEVID:  io_rdata = DEV_ID;
            IDX_DEVREV: io_rdata = DEV_REV;
            IDX_PWRCTL: io_rdata = pwr_ctl;
            IDX_PWRMGT: io_rdata = pwrmgt_q;
            IDX_OSC:    io_rdata = osc_q;
            default:    io_rdata = bank_val;
         endcase
      end
   end

   assert_run_data_ignored_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (!cfg_mode && dat_wr) |=> ($stable(dev_enable) && $stable(dev_base) && $stable(dev_irq)));
   assert_run_reads_ff_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (!cfg_mode && io_rd && hit_dat) |-> (io_rdata == 8'hFF));
   assert_pwrctl_view_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_mode && io_rd && hit_dat && index_q == IDX_PWRCTL) |->
      (io_rdata[7:6] == 2'b00 && io_rdata[5:0] == dev_enable[5:0]));
   assert_bad_ldn_no_effect_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_mode && dat_wr && ldn_q >= 8'(NUM_DEV) && index_q >= IDX_ACT) |=>
      ($stable(dev_enable) && $stable(dev_base)));
endmodule

// File: tb/sio_cfg_port_tb.sv
module sio_cfg_port_tb_top;
   localparam int ND = 9;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          strap_alt = 1'b0;
   logic [15:0]   io_addr = '0;
   logic          io_wr = 1'b0;
   logic          io_rd = 1'b0;
   logic [7:0]    io_wdata = '0;
   logic [7:0]    io_rdata;
   logic          cfg_mode;
   logic [ND-1:0] dev_enable;
   logic [ND*16-1:0] dev_base;
   logic [ND*8-1:0]  dev_irq, dev_irq2, dev_dma;
   logic [7:0]    fdd_mode, fdd_option;

   int checks = 0;
   int failures = 0;
   logic [15:0] cur_base = 16'h03F0;

   always #2 clk = ~clk;

   sio_cfg_port dut_i (
      .clk(clk), .rst_n(rst_n), .strap_alt(strap_alt),
      .io_addr(io_addr), .io_wr(io_wr), .io_rd(io_rd),
      .io_wdata(io_wdata), .io_rdata(io_rdata), .cfg_mode(cfg_mode),
      .dev_enable(dev_enable), .dev_base(dev_base), .dev_irq(dev_irq),
      .dev_irq2(dev_irq2), .dev_dma(dev_dma),
      .fdd_mode(fdd_mode), .fdd_option(fdd_option)
   );

   // vector: {is_read, port(0 index/1 data), byte (write data or expected read)}
   localparam int NV = 28;
   localparam logic [9:0] VEC [NV] = '{
      {2'b00, 8'h55}, {2'b00, 8'h55}, {2'b00, 8'h07}, {2'b01, 8'h04},
      {2'b00, 8'h60}, {2'b01, 8'h03}, {2'b00, 8'h61}, {2'b01, 8'hF8},
      {2'b00, 8'h70}, {2'b01, 8'h04}, {2'b00, 8'h30}, {2'b01, 8'hFF},
      {2'b11, 8'h01}, {2'b00, 8'h61}, {2'b11, 8'hF8}, {2'b10, 8'h61},
      {2'b00, 8'h07}, {2'b01, 8'h05}, {2'b00, 8'h61}, {2'b11, 8'h00},
      {2'b00, 8'h22}, {2'b11, 8'h10}, {2'b00, 8'h20}, {2'b11, 8'h02},
      {2'b00, 8'h21}, {2'b11, 8'h01}, {2'b00, 8'h07}, {2'b11, 8'h05}
   };

   task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic wr(input logic port, input logic [7:0] d);
      @(negedge clk);
      io_addr  = cur_base + {15'd0, port};
      io_wdata = d;
      io_wr    = 1'b1;
      @(negedge clk);
      io_wr    = 1'b0;
   endtask

   task automatic rd_at(input logic [15:0] a, input logic [7:0] exp, input string tag);
      @(negedge clk);
      io_addr = a;
      io_rd   = 1'b1;
      #1;
      chk({24'd0, io_rdata}, {24'd0, exp}, tag);
      io_rd   = 1'b0;
   endtask

   task automatic rd(input logic port, input logic [7:0] exp, input string tag);
      rd_at(cur_base + {15'd0, port}, exp, tag);
   endtask

   task automatic do_reset();
      rst_n = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
   endtask

   initial begin
      #400000;
      failures++;
      $display("FAIL R12 watchdog actual=timeout expected=finish");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      logic [7:0] rmw;
      do_reset();
      // R12 reset state
      chk({31'd0, cfg_mode}, 0, "R12 cfg_mode after reset");
      chk({23'd0, dev_enable}, 0, "R12 dev_enable after reset");
      chk(dev_base[31:0], 0, "R12 dev_base after reset");
      chk({24'd0, fdd_mode}, 0, "R12 fdd_mode after reset");
      rd(1'b1, 8'hFF, "R3 run-mode data read");

      // table walk: R1 unlock, R5, R6, R9
      for (int k = 0; k < NV; k++) begin
         if (VEC[k][9]) rd(VEC[k][8], VEC[k][7:0], $sformatf("R6 vector %0d", k));
         else           wr(VEC[k][8], VEC[k][7:0]);
      end
      chk({31'd0, cfg_mode}, 1, "R1 unlocked by table");
      chk({23'd0, dev_enable}, 32'h010, "R6 dev4 enabled");
      chk({16'd0, dev_base[4*16 +: 16]}, 32'h03F8, "R6 dev4 base");
      chk({24'd0, dev_irq[4*8 +: 8]}, 4, "R6 dev4 irq");
      wr(0, 8'h20); rd(0, 8'h20, "R5 index readback");

      // R10 global bytes
      wr(0, 8'h23); wr(1, 8'h5A); rd(1, 8'h5A, "R10 pwr mgt");
      wr(0, 8'h24); wr(1, 8'hA5); rd(1, 8'hA5, "R10 osc");

      // R7 device-only registers
      wr(0, 8'h07); wr(1, 8'h04);
      wr(0, 8'h74); wr(1, 8'h05); rd(1, 8'h00, "R7 dma absent on dev4");
      chk({24'd0, dev_dma[4*8 +: 8]}, 0, "R7 dev4 dma output");
      wr(0, 8'h72); wr(1, 8'h09); rd(1, 8'h00, "R7 irq2 absent on dev4");
      wr(0, 8'h07); wr(1, 8'h03);
      wr(0, 8'h74); wr(1, 8'h03); rd(1, 8'h03, "R7 dma on parallel");
      chk({24'd0, dev_dma[3*8 +: 8]}, 3, "R7 dev3 dma output");
      wr(0, 8'h07); wr(1, 8'h07);
      wr(0, 8'h72); wr(1, 8'h0C); rd(1, 8'h0C, "R7 irq2 on keyboard");
      chk({24'd0, dev_irq2[7*8 +: 8]}, 12, "R7 dev7 irq2 output");
      wr(0, 8'h30); wr(1, 8'h01);

      // R9 power control view
      wr(0, 8'h22); rd(1, 8'h10, "R9 bits 7:6 zero with dev7 on");
      wr(1, 8'hFF); rd(1, 8'h10, "R9 read-only");
      chk({23'd0, dev_enable}, 32'h090, "R9 dev_enable");

      // R8 floppy read-modify-write
      wr(0, 8'h07); wr(1, 8'h00);
      wr(0, 8'h90); wr(1, 8'h41); rd(1, 8'h41, "R8 mode write");
      @(negedge clk); io_addr = cur_base + 16'd1; io_rd = 1'b1; #1; rmw = io_rdata; io_rd = 1'b0;
      wr(1, rmw | 8'h0E); rd(1, 8'h4F, "R8 burst rmw");
      chk({24'd0, fdd_mode}, 32'h4F, "R8 fdd_mode output");
      wr(0, 8'h91); wr(1, 8'h3C); rd(1, 8'h3C, "R8 option");
      chk({24'd0, fdd_option}, 32'h3C, "R8 fdd_option output");

      // R11 unimplemented and out-of-range device
      wr(0, 8'h40); wr(1, 8'h33); rd(1, 8'h00, "R11 unimplemented index");
      wr(0, 8'h07); wr(1, 8'h0A);
      wr(0, 8'h30); wr(1, 8'h01); rd(1, 8'h00, "R11 ldn out of range");
      chk({23'd0, dev_enable}, 32'h090, "R11 enables unchanged");

      // R4 off-address and strobe-low reads
      rd_at(16'h02F8, 8'h00, "R4 foreign address");
      @(negedge clk); io_addr = cur_base; io_rd = 1'b0; #1;
      chk({24'd0, io_rdata}, 0, "R4 rd low");

      // R3 lock, run-mode writes ignored
      wr(0, 8'h07); wr(1, 8'h07); wr(0, 8'h30);
      wr(0, 8'hAA);
      chk({31'd0, cfg_mode}, 0, "R3 locked");
      rd(1, 8'hFF, "R3 run data read");
      rd(0, 8'hFF, "R3 run index read");
      wr(1, 8'h00);
      chk({23'd0, dev_enable}, 32'h090, "R3 run write ignored");

      // R2 interrupted unlock
      wr(0, 8'h55); wr(1, 8'h12); wr(0, 8'h55);
      chk({31'd0, cfg_mode}, 0, "R2 data write restarts");
      wr(0, 8'h00); wr(0, 8'h55);
      chk({31'd0, cfg_mode}, 0, "R2 index write restarts");
      wr(0, 8'h55);
      chk({31'd0, cfg_mode}, 1, "R1 unlock after restart");
      rd(0, 8'h30, "R5 index kept across lock");
      rd(1, 8'h01, "R3 kbd activate survived run write");
      wr(0, 8'hAA);

      // R12 reset with alternate strap, R4 address pair
      rst_n = 1'b0; strap_alt = 1'b1;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      chk({23'd0, dev_enable}, 0, "R12 enables cleared");
      chk({24'd0, dev_irq2[7*8 +: 8]}, 0, "R12 irq2 cleared");
      wr(0, 8'h55); wr(0, 8'h55);
      chk({31'd0, cfg_mode}, 0, "R4 primary pair ignored under alt strap");
      cur_base = 16'h0370;
      wr(0, 8'h55); wr(0, 8'h55);
      chk({31'd0, cfg_mode}, 1, "R4 alt pair unlocks");
      rd(0, 8'h00, "R12 index reset");
      wr(0, 8'h07); rd(1, 8'h00, "R12 ldn reset");
      wr(0, 8'h20); rd(1, 8'h02, "R5 device id alt");

      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule